// File: doc/BRIEF.md
# SPI Burst Transfer Engine

The engine runs a master-side SPI exchange of whole 8-bit words. A single start pulse begins a burst whose length comes from a total-length count. A second count says how many of those words are taken from an external transmit byte queue. Every word after that count goes out as zero, so a burst can be write-only, read-only or mixed. The received words are pushed into an external receive byte queue. A drop mode suppresses those pushes for bursts where only transmission matters.

Serial timing comes from a divider strobe, `tick_i`. Each strobe is one half period of the serial clock, so a word costs sixteen strobes. Clock polarity, clock phase and bit order are captured when the burst starts. The engine drives one of four select lines. The line follows the engine's busy state in automatic mode, or a fixed level in manual mode. When the burst ends, a sticky done flag is set. It raises the interrupt when enabled and is cleared by a clear pulse.

Top module: `spi_burst_eng`

## Requirements
- R1: A one-cycle `start_i` while idle latches `burst_len_i` and makes `busy_o` high. The burst then produces exactly 16 serial clock transitions per word, and `busy_o` drops by itself after the last word. A `start_i` seen while busy has no effect on the running burst.
- R2: Word i of a burst (counting from 0) carries the next transmit queue byte when i < `tx_len_i`, and 0x00 otherwise. Each word taken from the queue causes exactly one `tx_pop_o` cycle.
- R3: Each completed word is pushed once through `rx_push_o`/`rx_byte_o`, with the bits as sampled from `miso_i`. When `rx_drop_i` is 1, no push happens at all.
- R4: While idle, `sclk_o` equals `cpol_i`. The first transition of each bit pair is the leading edge. With `cpha_i`=0, the engine samples on the leading edge and the slave's data changes on the trailing edge. With `cpha_i`=1, it is the other way round.
- R5: The most significant bit goes first on both lines when `lsb_first_i`=0. The least significant bit goes first when `lsb_first_i`=1.
- R6: `done_o` becomes 1 in the cycle `busy_o` falls and stays 1 until a `done_clr_i` pulse. `irq_o` equals `done_o` AND `irq_en_i`.
- R7: With `cs_man_i`=0, the line chosen by `cs_idx_i` is at the active level while busy and at the inactive level otherwise. The active level is 1 if `cs_hi_i`=1 and 0 if `cs_hi_i`=0. All other lines stay inactive, so at most one line is ever active.
- R8: With `cs_man_i`=1, the chosen line equals `cs_lvl_i` whether or not a burst runs. The other lines stay inactive.
- R9: If the transmit queue is empty when a word that needs queue data is due, the serial clock holds at its idle level until a byte arrives. The burst then completes normally.
- R10: A start with `burst_len_i` = 0 completes with `done_o` set and no serial clock transition.
- R11: `tx_pop_o` is never high while `tx_empty_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-period strobe from the divider |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Sample on the trailing edge when 1 |
| lsb_first_i | input | 1 | Least significant bit first when 1 |
| rx_drop_i | input | 1 | Suppress receive pushes when 1 |
| cs_hi_i | input | 1 | Select lines are active high when 1 |
| cs_idx_i | input | 2 | Chosen select line |
| cs_man_i | input | 1 | Manual select mode |
| cs_lvl_i | input | 1 | Level of the chosen line in manual mode |
| burst_len_i | input | 24 | Total words in the burst |
| tx_len_i | input | 24 | Words taken from the transmit queue |
| start_i | input | 1 | Launch pulse |
| irq_en_i | input | 1 | Interrupt enable |
| done_clr_i | input | 1 | Clear pulse for the done flag |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt request |
| tx_empty_i | input | 1 | Transmit queue is empty |
| tx_byte_i | input | 8 | Head byte of the transmit queue |
| tx_pop_o | output | 1 | Take the head byte |
| rx_push_o | output | 1 | Receive byte valid |
| rx_byte_o | output | 8 | Received byte |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Select lines |

## Verification
The assertions take several things for granted:
- `cpol_i`, `cs_hi_i` and `rx_drop_i` stay constant from `start_i` until `busy_o` falls.
- The transmit queue presents a valid head byte whenever `tx_empty_i` is low.
- `tick_i` pulses are at least two cycles apart.

The stimulus changes configuration only while the engine is idle, with `done_o` already observed. It drives the strobe from a free-running divide-by-four counter. Its queue model shows `tx_empty_i` only from its own read and write pointers.

// File: rtl/spi_burst_eng.sv
module spi_burst_eng #(
  parameter int CW  = 24,
  parameter int NCS = 4,
  parameter int W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic                 lsb_first_i,
  input  logic                 rx_drop_i,
  input  logic                 cs_hi_i,
  input  logic [((NCS>1)?$clog2(NCS):1)-1:0] cs_idx_i,
  input  logic                 cs_man_i,
  input  logic                 cs_lvl_i,
  input  logic [CW-1:0]        burst_len_i,
  input  logic [CW-1:0]        tx_len_i,
  input  logic                 start_i,
  input  logic                 irq_en_i,
  input  logic                 done_clr_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 irq_o,
  input  logic                 tx_empty_i,
  input  logic [W-1:0]         tx_byte_i,
  output logic                 tx_pop_o,
  output logic                 rx_push_o,
  output logic [W-1:0]         rx_byte_o,
  output logic                 sclk_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic [NCS-1:0]       cs_o
);
  localparam int KW = $clog2(W);
  localparam int PW = KW + 1;
  localparam int IW = (NCS > 1) ? $clog2(NCS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} st_t;

  st_t          st;
  logic         cpol_q, cpha_q, lsb_q, drop_q, sck_t, mosi_q, done_q;
  logic [CW-1:0] burst_q, txl_q, idx;
  logic [PW-1:0] ph;
  logic [W-1:0] txb, rxb;

  function automatic logic pick(input logic [W-1:0] b, input logic [KW-1:0] k, input logic lsb);
    return lsb ? b[k] : b[W-1-int'(k)];
  endfunction

  wire          has_tx = idx < txl_q;
  wire          at_end = idx == burst_q;
  wire [W-1:0]  nb     = has_tx ? tx_byte_i : '0;
  wire          samp   = ~ph[0] ^ cpha_q;
  wire          last   = &ph;
  wire [KW-1:0] kn     = KW'((ph + PW'(1)) >> 1);
  wire [W-1:0]  rx_nxt = lsb_q ? {miso_i, rxb[W-1:1]} : {rxb[W-2:0], miso_i};

  assign busy_o   = st != S_IDLE;
  assign done_o   = done_q;
  assign irq_o    = done_q & irq_en_i;
  assign tx_pop_o = (st == S_LOAD) && !at_end && has_tx && !tx_empty_i;
  assign sclk_o   = (st == S_IDLE) ? cpol_i : (cpol_q ^ sck_t);
  assign mosi_o   = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cpol_q <= 1'b0; cpha_q <= 1'b0; lsb_q <= 1'b0; drop_q <= 1'b0;
      burst_q <= '0; txl_q <= '0; idx <= '0; ph <= '0;
      sck_t <= 1'b0; mosi_q <= 1'b0; done_q <= 1'b0;
      txb <= '0; rxb <= '0;
      rx_push_o <= 1'b0; rx_byte_o <= '0;
    end else begin
      rx_push_o <= 1'b0;
      if (done_clr_i) done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          cpol_q <= cpol_i; cpha_q <= cpha_i; lsb_q <= lsb_first_i; drop_q <= rx_drop_i;
          burst_q <= burst_len_i; txl_q <= tx_len_i; idx <= '0; sck_t <= 1'b0;
          st <= S_LOAD;
        end
        S_LOAD: begin
          if (at_end) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end else if (!has_tx || !tx_empty_i) begin
            txb <= nb;
            if (!cpha_q) mosi_q <= pick(nb, '0, lsb_q);
            ph <= '0;
            st <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick_i) begin
          sck_t <= ~sck_t;
          ph <= ph + PW'(1);
          if (samp) rxb <= rx_nxt;
          if (!samp && !(!cpha_q && last)) mosi_q <= pick(txb, kn, lsb_q);
          if (last) begin
            rx_byte_o <= samp ? rx_nxt : rxb;
            rx_push_o <= !drop_q;
            idx <= idx + CW'(1);
            st <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = (cs_idx_i != IW'(i)) ? ~cs_hi_i :
                     cs_man_i ? cs_lvl_i :
                     busy_o ? cs_hi_i : ~cs_hi_i;
  end
endmodule

// File: rtl/spi_burst_eng_chk.sv
module spi_burst_eng_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           irq,
  input logic           sclk,
  input logic           cpol,
  input logic           tx_pop,
  input logic           tx_empty,
  input logic           rx_push,
  input logic           drop,
  input logic           cs_hi,
  input logic [NCS-1:0] cs
);
  a_r11_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  a_r6_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r3_no_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !drop);

  a_r1_push_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> busy);

  a_r4_idle_level_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sclk) == cpol);

  a_r7_one_active_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs ^ {NCS{~cs_hi}}) <= 1);
endmodule

bind spi_burst_eng spi_burst_eng_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .irq(irq_o),
  .sclk(sclk_o), .cpol(cpol_i), .tx_pop(tx_pop_o), .tx_empty(tx_empty_i),
  .rx_push(rx_push_o), .drop(drop_q), .cs_hi(cs_hi_i), .cs(cs_o)
);

// File: tb/test_spi_burst_eng.sv
`timescale 1ns/1ps
module test_spi_burst_eng;
  logic clk = 0, rst_n = 0, tick = 0;
  logic cpol = 0, cpha = 0, lsb = 0, drop = 0, cs_hi = 0, cs_man = 0, cs_lvl = 0;
  logic [1:0] cs_idx = 0;
  logic [23:0] blen = 0, tlen = 0;
  logic start = 0, irq_en = 0, dclr = 0;
  logic busy, done, irq, tx_pop, rx_push, sclk, mosi, miso;
  logic [7:0] rx_byte;
  logic [3:0] cs;

  logic [7:0] txq [0:31];
  int twr = 0, trd = 0;
  logic [7:0] rxq [0:31];
  int rcnt = 0;
  logic [7:0] scap [0:31];
  logic [7:0] s_seed = 0;
  int sn = 0;
  logic sprev = 0, bprev = 0;
  int total = 0, bad = 0, tcnt = 0;

  wire tx_empty = (twr == trd);
  wire [7:0] tx_head = txq[trd[4:0]];

  spi_burst_eng i_spi_burst_eng (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .rx_drop_i(drop), .cs_hi_i(cs_hi), .cs_idx_i(cs_idx),
    .cs_man_i(cs_man), .cs_lvl_i(cs_lvl), .burst_len_i(blen), .tx_len_i(tlen),
    .start_i(start), .irq_en_i(irq_en), .done_clr_i(dclr), .busy_o(busy),
    .done_o(done), .irq_o(irq), .tx_empty_i(tx_empty), .tx_byte_i(tx_head),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_byte_o(rx_byte), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .cs_o(cs));

  always #10 clk = ~clk;

  function automatic logic [7:0] txv(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction
  function automatic logic [7:0] rxv(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 29);
  endfunction

  // slave bit index and miso drive
  int sbit;
  always_comb begin
    sbit = cpha ? ((sn == 0) ? 0 : (sn - 1) / 2) : sn / 2;
    miso = rxv(s_seed, sbit / 8)[lsb ? (sbit % 8) : (7 - sbit % 8)];
  end

  always @(posedge clk) begin
    if (tx_pop) trd <= trd + 1;
    if (rx_push) begin rxq[rcnt[4:0]] <= rx_byte; rcnt <= rcnt + 1; end
  end

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
    if (busy && !bprev) sn = 0;
    if (busy && sclk != sprev) begin
      sn = sn + 1;
      if ((cpha == 0 && sn % 2 == 1) || (cpha == 1 && sn % 2 == 0)) begin
        automatic int b = (sn - 1) / 2;
        scap[(b / 8) % 32][lsb ? (b % 8) : (7 - b % 8)] = mosi;
      end
    end
    sprev = sclk;
    bprev = busy;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R1 burst completes", done, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic clear_done();
    @(negedge clk) dclr = 1;
    @(negedge clk) dclr = 0;
  endtask

  task automatic prep(input logic [3:0] m, input int bl, input int tl, input logic [7:0] stx,
                      input logic [7:0] srx, input bit preload);
    @(negedge clk);
    {cpol, cpha, lsb, drop} = m;
    blen = 24'(bl); tlen = 24'(tl); s_seed = srx;
    rcnt = 0;
    for (int i = 0; i < 32; i++) scap[i] = 8'hxx;
    if (preload) for (int i = 0; i < tl; i++) begin txq[twr[4:0]] = txv(stx, i); twr++; end
  endtask

  task automatic check_burst(input int bl, input int tl, input logic [7:0] stx,
                             input logic [7:0] srx, input logic dr);
    chk(sn == 16 * bl, "R1 edge count", sn, 16 * bl);
    chk(rcnt == (dr ? 0 : bl), "R3 push count", rcnt, dr ? 0 : bl);
    if (!dr) for (int i = 0; i < bl; i++)
      chk(rxq[i] === rxv(srx, i), "R3/R4/R5 rx byte", rxq[i], rxv(srx, i));
    for (int i = 0; i < bl; i++)
      chk(scap[i] === ((i < tl) ? txv(stx, i) : 8'h00), "R2/R4/R5 mosi byte",
          scap[i], (i < tl) ? txv(stx, i) : 8'h00);
    chk(trd == twr, "R2 pops match", trd, twr);
  endtask

  // {cpol,cpha,lsb,drop}, burst, txlen, tx seed, rx seed
  localparam logic [35:0] VEC [7] = '{
    {4'b0000, 8'd3, 8'd3, 8'hA5, 8'h3C},
    {4'b0100, 8'd4, 8'd4, 8'h12, 8'hC3},
    {4'b1000, 8'd2, 8'd2, 8'h5A, 8'h81},
    {4'b1100, 8'd3, 8'd1, 8'h77, 8'h0F},
    {4'b0010, 8'd4, 8'd4, 8'h96, 8'hE7},
    {4'b0110, 8'd2, 8'd0, 8'h00, 8'h55},
    {4'b1001, 8'd3, 8'd3, 8'h33, 8'h44}
  };

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 reset idle", busy, 0);
    chk(!done && !irq, "R6 reset flags", {done, irq}, 0);
    chk(sclk == cpol, "R4 idle sclk", sclk, cpol);
    chk(cs == 4'b1111, "R7 reset cs inactive", cs, 4'hF);

    foreach (VEC[v]) begin
      automatic logic [35:0] e = VEC[v];
      prep(e[35:32], int'(e[31:24]), int'(e[23:16]), e[15:8], e[7:0], 1);
      pulse_start();
      wait_done();
      check_burst(int'(e[31:24]), int'(e[23:16]), e[15:8], e[7:0], e[32]);
      chk(sclk == cpol, "R4 sclk back idle", sclk, cpol);
      clear_done();
    end

    // R10 zero-length burst
    prep(4'b0000, 0, 0, 0, 0, 1);
    pulse_start();
    wait_done();
    chk(sn == 0, "R10 no edges", sn, 0);
    chk(!busy, "R10 idle", busy, 0);

    // R6 interrupt gating and clear
    @(negedge clk);
    chk(done && !irq, "R6 irq masked", irq, 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq, "R6 irq enabled", irq, 1);
    clear_done();
    chk(!done && !irq, "R6 clear", {done, irq}, 0);
    irq_en = 0;

    // R1 start while busy ignored; R7 auto select during burst
    cs_idx = 2;
    prep(4'b0000, 2, 2, 8'h21, 8'h9B, 1);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(cs == 4'b1011, "R7 active low selected", cs, 4'b1011);
    blen = 5;
    pulse_start();
    wait_done();
    check_burst(2, 2, 8'h21, 8'h9B, 0);
    repeat (40) @(negedge clk);
    chk(!busy && sn == 32, "R1 restart ignored", sn, 32);
    chk(cs == 4'b1111, "R7 idle inactive", cs, 4'hF);
    clear_done();

    // R7 active high, R9 stall on empty queue
    cs_hi = 1; cs_idx = 1;
    prep(4'b0100, 2, 2, 8'hC8, 8'h6E, 0);
    pulse_start();
    repeat (60) @(negedge clk);
    chk(busy && sn == 0, "R9 clock held", sn, 0);
    chk(cs == 4'b0010, "R7 active high selected", cs, 4'b0010);
    for (int i = 0; i < 2; i++) begin txq[twr[4:0]] = txv(8'hC8, i); twr++; end
    wait_done();
    check_burst(2, 2, 8'hC8, 8'h6E, 0);
    clear_done();

    // R8 manual select
    cs_hi = 0; cs_man = 1; cs_idx = 3; cs_lvl = 1;
    @(negedge clk);
    chk(cs == 4'b1111, "R8 manual high", cs, 4'hF);
    cs_lvl = 0;
    @(negedge clk);
    chk(cs == 4'b0111, "R8 manual low", cs, 4'b0111);
    prep(4'b0000, 1, 1, 8'h3E, 8'hD2, 1);
    cs_lvl = 1;
    pulse_start();
    repeat (10) @(negedge clk);
    chk(busy && cs == 4'b1111, "R8 manual ignores busy", cs, 4'hF);
    wait_done();
    check_burst(1, 1, 8'h3E, 8'hD2, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule